// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial link for a processor bus. Software reaches it through three word-wide registers using plain load and store strobes. The control register sets the character format. The status register reports the state of both directions. The data register takes a character to send and gives back the last character received. The serial side has one output line and one input line. Both lines idle high.

The character format is set at run time:
- 5 to 8 data bits per character.
- Parity disabled, even or odd.
- A stop period of one, one and a half or two bit times.
- A bit-rate divisor that sets how often the oversampling tick fires. Every bit lasts sixteen ticks.

The receiver resynchronises the input line. It finds a start bit on a falling edge, checks it half a bit later and samples every following bit at its centre. It flags parity mismatches and low stop bits.

The data register holds a single character in each direction. A write to the transmitter while it is busy is dropped. A read of the receive data acknowledges the character and its error flags.

Top module: `serial_xcvr`

## Requirements
- R1: After reset:
  - `txOut` is 1.
  - The status register reads 0x0001.
  - The control register reads 0x0003, which means 8 data bits, no parity, one stop bit and divisor 0.
- R2: Address map:
  - Address 0 is the control register, readable and writable.
  - Address 1 is the status register. Its bits are [0] transmitter empty, [1] receive data ready, [2] parity error and [3] framing error. All upper bits read 0.
  - Address 2 is the data register. A write sends a character and a read returns the received character, zero-extended.
  - Address 3 reads 0.
- R3: Control register fields:
  - [1:0] is the length code. The number of data bits is 5 plus the code.
  - [2] enables parity.
  - [3] selects odd parity.
  - [5:4] is the stop code: 0 for one bit, 1 for one and a half bits, 2 or 3 for two bits.
  - [15:8] is the divisor D. One oversampling tick occurs every D+1 clocks, and one bit time is 16 ticks.
- R4: An accepted data write takes `txOut` low for the start bit from the cycle after the write. The start bit lasts one bit time. The data bits follow, least significant first, each lasting one bit time. `txOut` is high whenever nothing is being sent.
- R5: With parity enabled, one parity bit follows the last data bit. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number of ones.
- R6: The stop period holds the line high for 16, 24 or 32 ticks. Transmitter empty reads 0 from the cycle after an accepted write until the end of the stop period. Transmitter empty returns to 1 in the cycle after the stop period ends.
- R7: A data write while the transmitter is busy is ignored. The character in flight and its timing are unchanged, and transmitter empty stays 0.
- R8: A falling edge on the synchronised input starts a receive. If the line is high again 8 ticks later, the receive is abandoned and no character is reported.
- R9: Each later bit is sampled 16 ticks after the previous one. If the line falls in cycle c, receive data ready reads 1 from cycle c+3+(8+16·(n+1))·(D+1), where n is the data-bit count plus the parity bit.
- R10: On each completed receive, the parity error flag takes the result of the parity check, and the framing error flag is set when the stop bit was sampled low. Both flags are replaced on every completion.
- R11: A read of the data register clears ready and both error flags. If a new character completes in the same cycle as the read, the new character wins: ready stays 1 and the new data and flags are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 2 | Register select |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; a read of the data register acknowledges it |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the register that `addr` selects |
| rxIn | input | 1 | Serial input line |
| txOut | output | 1 | Serial output line |

## Verification
Two functions can meet in one cycle:
- A completing receive, which sets ready, and a read of the data register, which clears it. The bench places the read strobe exactly on the completion edge it predicts for a second character. It then checks that the read returns the first character, that ready stays 1, and that the next read returns the second character.
- A character being sent while another arrives. The bench starts both at once and compares the line and the status against its model on every clock.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;

  localparam int OVS       = 16;
  localparam int MIN_DATA  = 5;
  localparam int MAX_DATA  = 8;
  localparam int FRAME_MAX = 1 + MAX_DATA + 1;
  localparam int LEN_W     = 4;
  localparam int FMT_W     = 6;
  localparam int DIV_LSB   = 8;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_DATA = 2;

  typedef enum logic [1:0] {
    STOP_1   = 2'd0,
    STOP_1P5 = 2'd1,
    STOP_2   = 2'd2,
    STOP_2B  = 2'd3
  } stopSelE;

  // packed order puts lenSel in the two low bits of the control word
  typedef struct packed {
    stopSelE    stopSel;
    logic       parityOdd;
    logic       parityOn;
    logic [1:0] lenSel;
  } fmtT;

  typedef struct packed {
    logic                txLoad;
    logic [MAX_DATA-1:0] txByte;
  } ctlStrobeT;

  typedef struct packed {
    logic                txBusy;
    logic                rxDone;
    logic                parityBad;
    logic                frameBad;
    logic [MAX_DATA-1:0] rxByte;
  } dpEventT;

  typedef struct packed {
    logic ready;
    logic parityErr;
    logic frameErr;
  } rxFlagsT;

endpackage

// File: rtl/serial_xcvr_tick.sv
module serial_xcvr_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (restart || count == divisor) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  assign tick = !restart && (count == divisor);

endmodule

// File: rtl/serial_xcvr_ctrl.sv
module serial_xcvr_ctrl
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output fmtT               fmt,
  output logic [DIV_W-1:0]  divisor,
  output ctlStrobeT         strobe,
  output rxFlagsT           rxFlags,
  input  dpEventT           dpEv
);

  logic                selCtrl, selStat, selData;
  logic                rxTake;
  logic [MAX_DATA-1:0] rxByteQ;

  assign selCtrl = (addr == ADDR_W'(ADDR_CTRL));
  assign selStat = (addr == ADDR_W'(ADDR_STAT));
  assign selData = (addr == ADDR_W'(ADDR_DATA));
  assign rxTake  = rdEn && selData;

  // format and divisor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmt     <= '{stopSel: STOP_1, parityOdd: 1'b0, parityOn: 1'b0, lenSel: 2'b11};
      divisor <= '0;
    end else if (wrEn && selCtrl) begin
      fmt     <= fmtT'(wrData[FMT_W-1:0]);
      divisor <= wrData[DIV_LSB +: DIV_W];
    end
  end

  // transmit acceptance: only when the datapath reports idle
  always_comb begin
    strobe.txLoad = wrEn && selData && !dpEv.txBusy;
    strobe.txByte = wrData[MAX_DATA-1:0];
  end

  // receive holding register; completion takes priority over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFlags <= '0;
      rxByteQ <= '0;
    end else if (dpEv.rxDone) begin
      rxFlags.ready     <= 1'b1;
      rxFlags.parityErr <= dpEv.parityBad;
      rxFlags.frameErr  <= dpEv.frameBad;
      rxByteQ           <= dpEv.rxByte;
    end else if (rxTake) begin
      rxFlags <= '0;
    end
  end

  always_comb begin
    rdData = '0;
    if (selCtrl) begin
      rdData[FMT_W-1:0]          = fmt;
      rdData[DIV_LSB +: DIV_W]   = divisor;
    end else if (selStat) begin
      rdData[0] = !dpEv.txBusy;
      rdData[1] = rxFlags.ready;
      rdData[2] = rxFlags.parityErr;
      rdData[3] = rxFlags.frameErr;
    end else if (selData) begin
      rdData[MAX_DATA-1:0] = rxByteQ;
    end
  end

endmodule

// File: rtl/serial_xcvr_dp.sv
module serial_xcvr_dp
  import serial_xcvr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fmtT              fmt,
  input  logic [DIV_W-1:0] divisor,
  input  ctlStrobeT        strobe,
  input  logic             rxIn,
  output logic             txOut,
  output dpEventT          dpEv
);

  localparam int CNT_W  = 6;
  localparam int RCNT_W = 4;
  localparam int NDIR   = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxStateE;

  logic [NDIR-1:0] restart, tick;

  genvar g;
  generate
    for (g = 0; g < NDIR; g++) begin : g_tick
      serial_xcvr_tick #(.DIV_W(DIV_W)) tick_i (
        .clk     (clk),
        .rstN    (rstN),
        .restart (restart[g]),
        .divisor (divisor),
        .tick    (tick[g])
      );
    end
  endgenerate

  // format decode shared by both directions
  logic [LEN_W-1:0]    dataLen;
  logic [MAX_DATA-1:0] dataMask;
  logic [CNT_W-1:0]    stopTicks;

  always_comb begin
    dataLen = LEN_W'(MIN_DATA) + LEN_W'(fmt.lenSel);
    for (int i = 0; i < MAX_DATA; i++) begin
      dataMask[i] = (LEN_W'(i) < dataLen);
    end
    case (fmt.stopSel)
      STOP_1:   stopTicks = CNT_W'(OVS);
      STOP_1P5: stopTicks = CNT_W'(OVS + OVS / 2);
      default:  stopTicks = CNT_W'(2 * OVS);
    endcase
  end

  // ---------------- transmit ----------------
  logic [FRAME_MAX-1:0] txFrameNext, txShift;
  logic [LEN_W-1:0]     txBitsNext, txLeft;
  logic [CNT_W-1:0]     txCnt;
  logic                 txBusy, txStop, txLine;
  logic [MAX_DATA-1:0]  txData;

  always_comb begin
    txData      = strobe.txByte & dataMask;
    txFrameNext = '1;
    txFrameNext[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (dataMask[i]) txFrameNext[i+1] = txData[i];
    end
    if (fmt.parityOn) txFrameNext[LEN_W'(1) + dataLen] = (^txData) ^ fmt.parityOdd;
    txBitsNext = LEN_W'(1) + dataLen + LEN_W'(fmt.parityOn);
  end

  assign restart[DIR_TX] = strobe.txLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txStop  <= 1'b0;
      txShift <= '1;
      txLeft  <= '0;
      txCnt   <= '0;
      txLine  <= 1'b1;
    end else if (strobe.txLoad) begin
      txBusy  <= 1'b1;
      txStop  <= 1'b0;
      txShift <= txFrameNext;
      txLeft  <= txBitsNext;
      txCnt   <= '0;
      txLine  <= txFrameNext[0];
    end else if (txBusy && tick[DIR_TX]) begin
      if (!txStop) begin
        if (txCnt == CNT_W'(OVS - 1)) begin
          txCnt <= '0;
          if (txLeft == LEN_W'(1)) begin
            txStop <= 1'b1;
            txLine <= 1'b1;
          end else begin
            txShift <= txShift >> 1;
            txLine  <= txShift[1];
            txLeft  <= txLeft - 1'b1;
          end
        end else begin
          txCnt <= txCnt + 1'b1;
        end
      end else if (txCnt == stopTicks - 1'b1) begin
        txBusy <= 1'b0;
        txStop <= 1'b0;
        txCnt  <= '0;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  assign txOut = txLine;

  // ---------------- receive ----------------
  rxStateE           rxState;
  logic              rxMeta, rxSync, rxPrev, rxFall;
  logic [RCNT_W-1:0] rxCnt;
  logic [LEN_W-1:0]  rxIdx, rxBits;
  logic [MAX_DATA:0] rxShift;
  logic              rxLast;

  assign rxFall          = rxPrev && !rxSync;
  assign restart[DIR_RX] = (rxState == RX_IDLE) && rxFall;
  assign rxBits          = dataLen + LEN_W'(fmt.parityOn);
  assign rxLast          = tick[DIR_RX] && (rxState == RX_BITS) &&
                           (rxCnt == RCNT_W'(OVS - 1)) && (rxIdx == rxBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (rxFall) begin
            rxState <= RX_START;
            rxCnt   <= '0;
          end
        end
        RX_START: begin
          if (tick[DIR_RX]) begin
            if (rxCnt == RCNT_W'(OVS / 2 - 1)) begin
              rxCnt   <= '0;
              rxIdx   <= '0;
              rxState <= rxSync ? RX_IDLE : RX_BITS;
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick[DIR_RX]) begin
            if (rxCnt == RCNT_W'(OVS - 1)) begin
              rxCnt <= '0;
              if (rxIdx == rxBits) begin
                rxState <= RX_IDLE;
              end else begin
                rxShift[rxIdx] <= rxSync;
                rxIdx          <= rxIdx + 1'b1;
              end
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  logic [MAX_DATA-1:0] rxData;
  assign rxData = rxShift[MAX_DATA-1:0] & dataMask;

  always_comb begin
    dpEv.txBusy    = txBusy;
    dpEv.rxDone    = rxLast;
    dpEv.rxByte    = rxData;
    dpEv.frameBad  = !rxSync;
    dpEv.parityBad = fmt.parityOn && ((^rxData) ^ rxShift[dataLen] ^ fmt.parityOdd);
  end

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxIn,
  output logic              txOut
);

  fmtT              fmt;
  logic [DIV_W-1:0] divisor;
  ctlStrobeT        strobe;
  dpEventT          dpEv;
  rxFlagsT          rxFlags;

  serial_xcvr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .fmt     (fmt),
    .divisor (divisor),
    .strobe  (strobe),
    .rxFlags (rxFlags),
    .dpEv    (dpEv)
  );

  serial_xcvr_dp #(.DIV_W(DIV_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .fmt     (fmt),
    .divisor (divisor),
    .strobe  (strobe),
    .rxIn    (rxIn),
    .txOut   (txOut),
    .dpEv    (dpEv)
  );

endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              txOut,
  input logic              txBusy,
  input logic              txLoad,
  input logic              rxDone,
  input logic              rxReady,
  input logic              parityErr,
  input logic              frameErr
);

  logic dataRead;
  assign dataRead = rdEn && (addr == ADDR_W'(2));

  assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);

  assert_start_bit_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txOut);

  assert_load_only_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> !txBusy);

  assert_done_sets_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> rxReady);

  assert_read_clears_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !rxDone) |=> (!rxReady && !parityErr && !frameErr));

  assert_collision_keeps_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && rxDone) |=> rxReady);

endmodule

bind serial_xcvr serial_xcvr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .rdEn      (rdEn),
  .txOut     (txOut),
  .txBusy    (dpEv.txBusy),
  .txLoad    (strobe.txLoad),
  .rxDone    (dpEv.rxDone),
  .rxReady   (rxFlags.ready),
  .parityErr (rxFlags.parityErr),
  .frameErr  (rxFlags.frameErr)
);

// File: tb/serial_xcvr_tb.sv
module serial_xcvr_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rxIn = 1'b1;
  logic        txOut;

  always #4 clk = ~clk;

  serial_xcvr dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxIn(rxIn), .txOut(txOut)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string txTag = "R4";
  string rxTag = "R9";

  // model state
  logic [1:0] txQ[$];        // {empty, line} per cycle
  int         rxDoneAt = -1;
  int         clrAt = -1;
  bit         expReady = 0;
  int cfgLen = 8, cfgPar = 0, cfgOdd = 0, cfgStop = 0, cfgDiv = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [1:0] e;
      e = (txQ.size() > 0) ? txQ.pop_front() : 2'b11;
      chk(txOut == e[0], txTag, "serial out", int'(txOut), int'(e[0]));
      if (cyc == clrAt)    expReady = 0;
      if (cyc == rxDoneAt) expReady = 1;
      if (addr == 2'd1 && !wrEn) begin
        chk(rdData[0] == e[1], "R6", "tx empty", int'(rdData[0]), int'(e[1]));
        chk(rdData[1] == expReady, rxTag, "rx ready", int'(rdData[1]), int'(expReady));
      end
    end
  end

  function automatic logic parOf(logic [7:0] b, int len, int odd);
    logic p = 1'b0;
    for (int i = 0; i < len; i++) p ^= b[i];
    return p ^ odd[0];
  endfunction

  task automatic modelTx(logic [7:0] b);
    int d, st;
    d  = cfgDiv + 1;
    st = (cfgStop == 0) ? 16 : (cfgStop == 1) ? 24 : 32;
    txQ.push_back(2'b11);
    repeat (16 * d) txQ.push_back(2'b00);
    for (int i = 0; i < cfgLen; i++) repeat (16 * d) txQ.push_back({1'b0, b[i]});
    if (cfgPar != 0) repeat (16 * d) txQ.push_back({1'b0, parOf(b, cfgLen, cfgOdd)});
    repeat (st * d) txQ.push_back(2'b01);
  endtask

  task automatic busWrite(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    addr = a; wrData = d; wrEn = 1'b1;
    if (a == 2'd2 && txQ.size() == 0) modelTx(d[7:0]);
    @(posedge clk); #1;
    wrEn = 1'b0; addr = 2'd1;
  endtask

  task automatic busRead(logic [1:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    addr = a; rdEn = 1'b1;
    if (a == 2'd2) clrAt = cyc + 1;
    #2 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0; addr = 2'd1;
  endtask

  task automatic setCfg(int len, int par, int odd, int stopc, int dv);
    logic [15:0] w, r;
    w = {8'(dv), 2'b00, 2'(stopc), 1'(odd), 1'(par), 2'(len - 5)};
    busWrite(2'd0, w);
    cfgLen = len; cfgPar = par; cfgOdd = odd; cfgStop = stopc; cfgDiv = dv;
    busRead(2'd0, r);
    chk(r == w, "R3", "control readback", int'(r), int'(w));
  endtask

  task automatic sendRx(logic [7:0] b, bit badPar, bit stopV);
    int d, n;
    logic p;
    @(posedge clk); #1;
    d = cfgDiv + 1;
    n = cfgLen + cfgPar;
    rxDoneAt = cyc + 3 + (8 + 16 * (n + 1)) * d;
    p = parOf(b, cfgLen, cfgOdd) ^ badPar;
    rxIn = 1'b0;
    repeat (16 * d) @(posedge clk); #1;
    for (int i = 0; i < cfgLen; i++) begin
      rxIn = b[i];
      repeat (16 * d) @(posedge clk); #1;
    end
    if (cfgPar != 0) begin
      rxIn = p;
      repeat (16 * d) @(posedge clk); #1;
    end
    rxIn = stopV;
    repeat (16 * d) @(posedge clk); #1;
    rxIn = 1'b1;
  endtask

  task automatic settle();
    while (txQ.size() != 0 || cyc <= rxDoneAt + 1) begin
      @(posedge clk); #1;
    end
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    finishRun();
  end

  initial begin
    logic [15:0] r;
    repeat (5) @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(txOut == 1'b1, "R1", "reset line", int'(txOut), 1);
    chk(rdData == 16'h0001, "R1", "reset status", int'(rdData), 1);
    busRead(2'd0, r);
    chk(r == 16'h0003, "R1", "reset control", int'(r), 3);
    busRead(2'd3, r);
    chk(r == 16'h0000, "R2", "unused address", int'(r), 0);

    // R4: 8 bits, no parity, one stop, divisor 1
    txTag = "R4";
    setCfg(8, 0, 0, 0, 1);
    busWrite(2'd2, 16'h00A5);
    settle();

    // R5/R6: 5 bits even parity, 1.5 stop, divisor 2
    txTag = "R5";
    setCfg(5, 1, 0, 1, 2);
    busWrite(2'd2, 16'h0013);
    settle();

    // R7: 7 bits odd parity, two stop, divisor 0; write while busy
    txTag = "R7";
    setCfg(7, 1, 1, 2, 0);
    busWrite(2'd2, 16'h0055);
    repeat (40) @(posedge clk); #1;
    busWrite(2'd2, 16'h00FF);
    @(negedge clk);
    chk(rdData[0] == 1'b0, "R7", "empty after ignored write", int'(rdData[0]), 0);
    settle();
    txTag = "R6";
    busWrite(2'd2, 16'h0002);
    settle();

    // receive, 8N1 divisor 1
    txTag = "R4";
    rxTag = "R9";
    setCfg(8, 0, 0, 0, 1);
    sendRx(8'h3C, 1'b0, 1'b1);
    settle();
    busRead(2'd1, r);
    chk(r == 16'h0003, "R2", "status after receive", int'(r), 3);
    busRead(2'd2, r);
    chk(r == 16'h003C, "R9", "received byte", int'(r), 16'h3C);

    // R8: short glitch
    rxTag = "R8";
    @(posedge clk); #1;
    rxIn = 1'b0;
    repeat (6) @(posedge clk); #1;
    rxIn = 1'b1;
    repeat (80) @(posedge clk); #1;
    busRead(2'd1, r);
    chk(r[1] == 1'b0, "R8", "glitch not reported", int'(r[1]), 0);
    sendRx(8'h81, 1'b0, 1'b1);
    settle();
    busRead(2'd2, r);
    chk(r == 16'h0081, "R8", "byte after glitch", int'(r), 16'h81);

    // R10: parity error, 7 bits even
    rxTag = "R10";
    setCfg(7, 1, 0, 0, 1);
    sendRx(8'h2B, 1'b1, 1'b1);
    settle();
    busRead(2'd1, r);
    chk(r == 16'h0007, "R10", "parity error status", int'(r), 7);
    busRead(2'd2, r);
    chk(r == 16'h002B, "R10", "byte with parity error", int'(r), 16'h2B);
    busRead(2'd1, r);
    chk(r == 16'h0001, "R11", "flags cleared by read", int'(r), 1);

    // R10: framing error
    sendRx(8'h11, 1'b0, 1'b0);
    settle();
    busRead(2'd1, r);
    chk(r == 16'h000B, "R10", "framing error status", int'(r), 16'hB);
    busRead(2'd2, r);

    // 5 bits odd, clean
    setCfg(5, 1, 1, 0, 1);
    sendRx(8'h16, 1'b0, 1'b1);
    settle();
    busRead(2'd1, r);
    chk(r == 16'h0003, "R10", "clean odd-parity status", int'(r), 3);
    busRead(2'd2, r);
    chk(r == 16'h0016, "R9", "5-bit byte", int'(r), 16'h16);

    // R11: read on the completion edge
    rxTag = "R11";
    setCfg(8, 0, 0, 0, 1);
    sendRx(8'h5A, 1'b0, 1'b1);
    settle();
    fork
      sendRx(8'hC7, 1'b0, 1'b1);
      begin
        @(posedge clk); #2;
        while (cyc != rxDoneAt - 2) begin
          @(posedge clk); #1;
        end
        busRead(2'd2, r);
        chk(r == 16'h005A, "R11", "old byte on collision", int'(r), 16'h5A);
      end
    join
    settle();
    busRead(2'd1, r);
    chk(r[1] == 1'b1, "R11", "ready kept on collision", int'(r[1]), 1);
    busRead(2'd2, r);
    chk(r == 16'h00C7, "R11", "new byte kept", int'(r), 16'hC7);

    // simultaneous send and receive
    rxTag = "R9";
    fork
      busWrite(2'd2, 16'h00C3);
      sendRx(8'h69, 1'b0, 1'b1);
    join
    settle();
    busRead(2'd2, r);
    chk(r == 16'h0069, "R9", "byte during transmit", int'(r), 16'h69);

    finishRun();
  end

endmodule